// File: doc/BRIEF.md
# Rotational Drum Transfer Controller

This block controls a word-addressed rotating drum store that hangs off an I/O channel. A host issues a read-select or a write-select command. The controller either accepts the command or refuses it with a busy or an error answer. Accepting a command arms a direction and clears the drum address. A 12-bit angular position counter steps once per word-time tick. A word moves only when the counter, just after it steps, equals the low 12 bits of the address, and only while the channel is active and has selected the device.

The address register is a sparse 36-bit field. The controller repacks it into a 21-bit linear memory index whose top three bits name a storage unit. Units above the configured count are refused with end-of-record, attention and error. After each word the address steps under a fixed mask. End-of-record is also raised each time the low 11 address bits come back to zero. The channel can cut a transfer short with an end or a timing reply. It can drop the whole command by disconnecting. The memory side is an asynchronous-read, write-strobe port that is indexed by the repacked address.

Top module: `drum_xfer_ctl`

## Requirements
- R1: With storage attached, a command gets the busy answer (`cmd_resp` = 1) whenever `chan_active` is high or a previous command is still pending.
- R2: A command gets the error answer (`cmd_resp` = 2) when `attached` is low, or when its code is neither 1 (read-select) nor 2 (write-select).
- R3: An accepted command (`cmd_resp` = 0 with `cmd_valid`) pulses `sel_set` in the same cycle, with `sel_dir` = 0 for read and 1 for write. It sets the matching direction flag and the pending flag, and it clears the address register to zero.
- R4: The position counter steps by one on each `tick` and wraps from 4095 to 0. A word is matched against the stepped value, so after reset with address 0 the first word moves on the 4096th tick.
- R5: A word moves (`word_strobe`) only in a tick cycle in which `chan_active` and `chan_sel` are both high, a direction flag is set, and the stepped position equals address bits 11:0. A read drives `mem_rdata` to `word_to_chan` with `mem_re`. A write raises `mem_we` with `word_from_chan` only when `xfer_code` = 0 (0 ok, 1 channel end, 2 timing error, 3 no effect).
- R6: `mem_idx` is address bits 14:0 in index bits 14:0, address bits 20:18 in index bits 17:15, and address bits 32:30 in index bits 20:18 (the unit).
- R7: When the unit exceeds the configured count, no word moves, and `eor`, `attn` and `err` pulse together in that cycle.
- R8: After an accepted word (`xfer_code` = 0) the address becomes (address + 1) AND octal 070007077777. The 15-bit word offset therefore runs from 32767 back to index offset 0.
- R9: `eor` pulses with an accepted word whenever the stepped address has bits 10:0 all zero.
- R10: A reply of 1 or 2 on a moving word clears both direction flags and keeps the pending flag. No further words move, and commands stay busy.
- R11: A tick with `chan_disco` high while a command is pending clears all flags, pulses `sel_clr` and `eor_clr`, and no word moves in that cycle.
- R12: A synchronous active-high `rst` clears the flags, the address and the position. `unit_cfg` is captured only while no flag is set.
- R13: `addr_ld` writes `addr_ld_val` into the address register, except in a cycle where a command is accepted or a word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attached | input | 1 | Backing storage present |
| unit_cfg | input | 3 | Configured number of units |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code, 1 read-select, 2 write-select |
| cmd_resp | output | 2 | 0 accepted, 1 busy, 2 error |
| sel_set | output | 1 | Select the channel on acceptance |
| sel_dir | output | 1 | Channel direction with sel_set, 1 = channel to drum |
| addr_ld | input | 1 | Load the drum address |
| addr_ld_val | input | 36 | Address value to load |
| tick | input | 1 | Word-time tick |
| chan_active | input | 1 | Channel transfer active |
| chan_sel | input | 1 | Channel has selected this device |
| chan_disco | input | 1 | Channel disconnect |
| xfer_code | input | 2 | Channel reply to the moving word |
| word_strobe | output | 1 | A word moves this cycle |
| word_from_chan | input | 36 | Word from the channel (write) |
| word_to_chan | output | 36 | Word to the channel (read) |
| eor | output | 1 | End-of-record to the channel |
| attn | output | 1 | Attention to the channel |
| err | output | 1 | Error to the channel |
| sel_clr | output | 1 | Clear the channel select indication |
| eor_clr | output | 1 | Clear the channel end-of-record indication |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_idx | output | 21 | Linear memory index |
| mem_wdata | output | 36 | Memory write data |
| mem_rdata | input | 36 | Memory read data, same cycle |

## Verification
The hardest condition to reach is the out-of-range unit. A command always clears the address, and stepping alone can never carry into the unit field. The stimulus therefore loads an address with unit 5 while a read is pending. It also raises `unit_cfg` during that command, so the refusal shows that the count captured while idle is the one still in use. Offset wrap and the 2048-word boundary also need a loaded start offset of 32766 or long runs of consecutive words. To get those runs, the bench keeps `tick` high so that every matched word is followed at once by the next.

// File: rtl/drum_pkg.sv
package drum_pkg;
   typedef enum logic [1:0] {
      RSP_OK    = 2'd0,
      RSP_BUSY  = 2'd1,
      RSP_IOERR = 2'd2
   } drum_rsp_e;

   localparam logic [2:0] OPC_RDS = 3'd1;
   localparam logic [2:0] OPC_WRS = 3'd2;

   localparam logic [1:0] CHR_OK   = 2'd0;
   localparam logic [1:0] CHR_END  = 2'd1;
   localparam logic [1:0] CHR_TERR = 2'd2;

   typedef struct packed {
      logic rd;
      logic wr;
      logic pend;
   } drum_stat_t;
endpackage

// File: rtl/drum_pos_ctr.sv
module drum_pos_ctr #(
   parameter int POS_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [POS_W-1:0] pos_q,
   output logic [POS_W-1:0] pos_nxt
);
   assign pos_nxt = pos_q + {{(POS_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst)       pos_q <= '0;
      else if (tick) pos_q <= pos_nxt;
   end
endmodule

// File: rtl/drum_addr_map.sv
module drum_addr_map #(
   parameter int ADDR_W   = 36,
   parameter int OFF_W    = 15,
   parameter int MID_LSB  = 18,
   parameter int MID_W    = 3,
   parameter int UNIT_LSB = 30,
   parameter int UNIT_W   = 3,
   localparam int IDX_W   = OFF_W + MID_W + UNIT_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [UNIT_W-1:0] unit
);
   logic unused_addr;
   assign unused_addr = ^addr;
   assign unit = addr[UNIT_LSB +: UNIT_W];

   generate
      if (MID_W > 0) begin : g_mid
         assign idx = {unit, addr[MID_LSB +: MID_W], addr[OFF_W-1:0]};
      end else begin : g_flat
         assign idx = {unit, addr[OFF_W-1:0]};
      end
   endgenerate
endmodule

// File: rtl/drum_cmd_ctl.sv
module drum_cmd_ctl
   import drum_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       attached,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       chan_active,
   input  logic       tick,
   input  logic       chan_disco,
   input  logic       word_abort,
   output drum_stat_t stat_q,
   output logic [1:0] resp,
   output logic       accept,
   output logic       disco_evt
);
   always_comb begin
      if (!attached)                        resp = RSP_IOERR;
      else if (chan_active || stat_q.pend)  resp = RSP_BUSY;
      else if (cmd_code == OPC_RDS || cmd_code == OPC_WRS) resp = RSP_OK;
      else                                  resp = RSP_IOERR;
   end

   assign accept    = cmd_valid && (resp == RSP_OK);
   assign disco_evt = tick && stat_q.pend && chan_disco;

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= '0;
      end else if (accept) begin
         stat_q.rd   <= (cmd_code == OPC_RDS);
         stat_q.wr   <= (cmd_code == OPC_WRS);
         stat_q.pend <= 1'b1;
      end else if (disco_evt) begin
         stat_q <= '0;
      end else if (word_abort) begin
         stat_q.rd <= 1'b0;
         stat_q.wr <= 1'b0;
      end
   end
endmodule

// File: rtl/drum_xfer_ctl.sv
module drum_xfer_ctl
   import drum_pkg::*;
#(
   parameter int WORD_W      = 36,
   parameter int ADDR_W      = 36,
   parameter int POS_W       = 12,
   parameter int OFF_W       = 15,
   parameter int MID_LSB     = 18,
   parameter int MID_W       = 3,
   parameter int UNIT_LSB    = 30,
   parameter int UNIT_W      = 3,
   parameter int EOR_W       = 11,
   parameter bit RANGE_CHECK = 1'b1,
   parameter logic [ADDR_W-1:0] ADDR_MASK = 36'o070007077777
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            attached,
   input  logic [UNIT_W-1:0]               unit_cfg,
   input  logic                            cmd_valid,
   input  logic [2:0]                      cmd_code,
   output logic [1:0]                      cmd_resp,
   output logic                            sel_set,
   output logic                            sel_dir,
   input  logic                            addr_ld,
   input  logic [ADDR_W-1:0]               addr_ld_val,
   input  logic                            tick,
   input  logic                            chan_active,
   input  logic                            chan_sel,
   input  logic                            chan_disco,
   input  logic [1:0]                      xfer_code,
   output logic                            word_strobe,
   input  logic [WORD_W-1:0]               word_from_chan,
   output logic [WORD_W-1:0]               word_to_chan,
   output logic                            eor,
   output logic                            attn,
   output logic                            err,
   output logic                            sel_clr,
   output logic                            eor_clr,
   output logic                            mem_re,
   output logic                            mem_we,
   output logic [OFF_W+MID_W+UNIT_W-1:0]   mem_idx,
   output logic [WORD_W-1:0]               mem_wdata,
   input  logic [WORD_W-1:0]               mem_rdata
);
   localparam int IDX_W = OFF_W + MID_W + UNIT_W;

   generate
      if (POS_W > OFF_W) begin : g_bad_pos
         $error("position counter wider than word offset");
      end
      if (EOR_W > OFF_W) begin : g_bad_eor
         $error("record boundary wider than word offset");
      end
      if (UNIT_LSB + UNIT_W > ADDR_W || MID_LSB + MID_W > UNIT_LSB) begin : g_bad_fld
         $error("address fields overlap or exceed the register");
      end
   endgenerate

   drum_stat_t          stat_q;
   logic [1:0]          resp;
   logic                accept, disco_evt;
   logic [POS_W-1:0]    pos_q, pos_nxt;
   logic [ADDR_W-1:0]   addr_q, addr_inc;
   logic [UNIT_W-1:0]   unit, cfg_q;
   logic [IDX_W-1:0]    idx;
   logic                go, in_range, word_go, word_ok, word_abort, oor;

   drum_cmd_ctl u_cmd (
      .clk(clk), .rst(rst), .attached(attached), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .chan_active(chan_active), .tick(tick),
      .chan_disco(chan_disco), .word_abort(word_abort), .stat_q(stat_q),
      .resp(resp), .accept(accept), .disco_evt(disco_evt)
   );

   drum_pos_ctr #(.POS_W(POS_W)) u_pos (
      .clk(clk), .rst(rst), .tick(tick), .pos_q(pos_q), .pos_nxt(pos_nxt)
   );

   drum_addr_map #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MID_LSB(MID_LSB), .MID_W(MID_W),
      .UNIT_LSB(UNIT_LSB), .UNIT_W(UNIT_W)
   ) u_map (
      .addr(addr_q), .idx(idx), .unit(unit)
   );

   generate
      if (RANGE_CHECK) begin : g_rng
         assign in_range = (unit <= cfg_q);
      end else begin : g_norng
         assign in_range = 1'b1;
      end
   endgenerate

   assign go = tick && chan_active && chan_sel && (stat_q.rd || stat_q.wr)
               && !disco_evt && (pos_nxt == addr_q[POS_W-1:0]);
   assign word_go    = go && in_range;
   assign oor        = go && !in_range;
   assign word_ok    = word_go && (xfer_code == CHR_OK);
   assign word_abort = word_go && (xfer_code == CHR_END || xfer_code == CHR_TERR);
   assign addr_inc   = (addr_q + {{(ADDR_W-1){1'b0}}, 1'b1}) & ADDR_MASK;

   assign cmd_resp     = resp;
   assign sel_set      = accept;
   assign sel_dir      = (cmd_code == OPC_WRS);
   assign sel_clr      = disco_evt;
   assign eor_clr      = disco_evt;
   assign word_strobe  = word_go;
   assign mem_idx      = idx;
   assign mem_re       = word_go && stat_q.rd;
   assign mem_we       = word_ok && stat_q.wr;
   assign mem_wdata    = word_from_chan;
   assign word_to_chan = mem_rdata;
   assign attn         = oor;
   assign err          = oor;
   assign eor          = oor || (word_ok && (addr_inc[EOR_W-1:0] == '0));

   always_ff @(posedge clk) begin
      if (rst)            addr_q <= '0;
      else if (accept)    addr_q <= '0;
      else if (word_ok)   addr_q <= addr_inc;
      else if (addr_ld)   addr_q <= addr_ld_val;
   end

   always_ff @(posedge clk) begin
      if (rst)                 cfg_q <= '0;
      else if (stat_q == '0)   cfg_q <= unit_cfg;
   end
endmodule

// File: rtl/drum_xfer_chk.sv
module drum_xfer_chk #(
   parameter int POS_W  = 12,
   parameter int ADDR_W = 36
) (
   input logic              clk,
   input logic              rst,
   input logic              attached,
   input logic              cmd_valid,
   input logic [1:0]        cmd_resp,
   input logic              tick,
   input logic              chan_active,
   input logic              chan_sel,
   input logic              chan_disco,
   input logic [1:0]        xfer_code,
   input logic              word_strobe,
   input logic              mem_re,
   input logic              mem_we,
   input logic              eor,
   input logic              attn,
   input logic              err,
   input logic [POS_W-1:0]  pos_q,
   input logic [ADDR_W-1:0] addr_q,
   input logic              rd,
   input logic              wr,
   input logic              pend
);
   p_busy_pending_r1: assert property (@(posedge clk) disable iff (rst)
      (attached && pend) |-> cmd_resp == 2'd1);

   p_detached_err_r2: assert property (@(posedge clk) disable iff (rst)
      !attached |-> cmd_resp == 2'd2);

   p_accept_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_resp == 2'd0) |=> (addr_q == '0) && pend);

   p_pos_step_r4: assert property (@(posedge clk) disable iff (rst)
      tick |=> pos_q == POS_W'($past(pos_q) + 1'b1));

   p_pos_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(pos_q));

   p_strobe_cond_r5: assert property (@(posedge clk) disable iff (rst)
      word_strobe |-> tick && chan_active && chan_sel && (rd || wr));

   p_mem_needs_strobe_r5: assert property (@(posedge clk) disable iff (rst)
      (mem_re || mem_we) |-> word_strobe);

   p_oor_flags_r7: assert property (@(posedge clk) disable iff (rst)
      attn |-> eor && err && !word_strobe);

   p_abort_keeps_pend_r10: assert property (@(posedge clk) disable iff (rst)
      (word_strobe && (xfer_code == 2'd1 || xfer_code == 2'd2))
      |=> pend && !rd && !wr);

   p_disco_clears_r11: assert property (@(posedge clk) disable iff (rst)
      (tick && chan_disco && pend) |=> !pend && !rd && !wr);
endmodule

bind drum_xfer_ctl drum_xfer_chk #(.POS_W(POS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .attached(attached), .cmd_valid(cmd_valid),
   .cmd_resp(cmd_resp), .tick(tick), .chan_active(chan_active),
   .chan_sel(chan_sel), .chan_disco(chan_disco), .xfer_code(xfer_code),
   .word_strobe(word_strobe), .mem_re(mem_re), .mem_we(mem_we), .eor(eor),
   .attn(attn), .err(err), .pos_q(pos_q), .addr_q(addr_q),
   .rd(stat_q.rd), .wr(stat_q.wr), .pend(stat_q.pend)
);

// File: tb/sim_drum_xfer_ctl.sv
module sim_drum_xfer_ctl;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst = 1'b1, attached = 1'b0, cmd_valid = 1'b0, addr_ld = 1'b0;
   logic [2:0]  unit_cfg = 3'd1, cmd_code = 3'd0;
   logic [35:0] addr_ld_val = '0, word_from_chan = 36'h0abc;
   logic        tick = 1'b0, chan_active = 1'b0, chan_sel = 1'b0, chan_disco = 1'b0;
   logic [1:0]  xfer_code = 2'd0;
   logic [1:0]  cmd_resp;
   logic        sel_set, sel_dir, word_strobe, eor, attn, err, sel_clr, eor_clr;
   logic        mem_re, mem_we;
   logic [35:0] word_to_chan, mem_wdata, mem_rdata;
   logic [20:0] mem_idx;

   localparam logic [35:0] MASK = 36'o070007077777;

   function automatic logic [35:0] pat(input logic [20:0] i);
      return {15'h1a5a, i} ^ 36'h123456789;
   endfunction
   assign mem_rdata = pat(mem_idx);

   drum_xfer_ctl u0 (
      .clk(clk), .rst(rst), .attached(attached), .unit_cfg(unit_cfg),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_resp(cmd_resp),
      .sel_set(sel_set), .sel_dir(sel_dir), .addr_ld(addr_ld),
      .addr_ld_val(addr_ld_val), .tick(tick), .chan_active(chan_active),
      .chan_sel(chan_sel), .chan_disco(chan_disco), .xfer_code(xfer_code),
      .word_strobe(word_strobe), .word_from_chan(word_from_chan),
      .word_to_chan(word_to_chan), .eor(eor), .attn(attn), .err(err),
      .sel_clr(sel_clr), .eor_clr(eor_clr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // reference state
   bit          m_rd = 0, m_wr = 0, m_pend = 0;
   logic [35:0] m_addr = '0;
   int          m_pos = 0;
   logic [2:0]  m_cfg = '0;
   int n_chk = 0, n_bad = 0, n_strobe = 0, n_attn = 0, n_eor = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      logic [1:0]  er;
      bit          acc, dsc, go, inr, strb, oor, ok, ab, eeor;
      int          pn;
      logic [20:0] eidx;
      logic [35:0] ainc;
      #1;
      if (!attached)                      er = 2'd2;
      else if (chan_active || m_pend)     er = 2'd1;
      else if (cmd_code == 3'd1 || cmd_code == 3'd2) er = 2'd0;
      else                                er = 2'd2;
      acc  = cmd_valid && er == 2'd0;
      dsc  = tick && m_pend && chan_disco;
      pn   = (m_pos + 1) % 4096;
      go   = tick && chan_active && chan_sel && (m_rd || m_wr) && !dsc
             && (pn == int'(m_addr[11:0]));
      eidx = {m_addr[32:30], m_addr[20:18], m_addr[14:0]};
      inr  = m_addr[32:30] <= m_cfg;
      strb = go && inr;
      oor  = go && !inr;
      ok   = strb && xfer_code == 2'd0;
      ab   = strb && (xfer_code == 2'd1 || xfer_code == 2'd2);
      ainc = (m_addr + 36'd1) & MASK;
      eeor = oor || (ok && ainc[10:0] == 11'd0);

      chk(er == 2'd2 ? "R2 resp" : (er == 2'd1 ? "R1 resp" : "R3 resp"), cmd_resp, er);
      chk("R5 word_strobe", word_strobe, strb);
      chk("R5 mem_re", mem_re, strb && m_rd);
      chk("R5 mem_we", mem_we, strb && m_wr && xfer_code == 2'd0);
      if (strb) begin
         chk((eidx[14:0] == 15'd0 && m_addr != '0) ? "R8 wrapped index" : "R6 index",
             mem_idx, eidx);
         if (m_rd) chk("R5 word to channel", word_to_chan, pat(eidx));
         if (m_wr && xfer_code == 2'd0) chk("R5 word to memory", mem_wdata, word_from_chan);
      end
      chk(oor ? "R7 eor" : "R9 eor", eor, eeor);
      chk("R7 attn", attn, oor);
      chk("R7 err", err, oor);
      chk("R3 sel_set", sel_set, acc);
      if (acc) chk("R3 sel_dir", sel_dir, cmd_code == 3'd2);
      chk("R11 sel_clr", sel_clr, dsc);
      chk("R11 eor_clr", eor_clr, dsc);
      if (word_strobe) n_strobe++;
      if (attn) n_attn++;
      if (eor) n_eor++;

      @(posedge clk);
      if (rst) begin
         m_rd = 0; m_wr = 0; m_pend = 0; m_addr = '0; m_pos = 0; m_cfg = '0;
      end else begin
         if (!m_rd && !m_wr && !m_pend) m_cfg = unit_cfg;
         if (tick) m_pos = pn;
         if (acc) begin
            m_rd = cmd_code == 3'd1; m_wr = cmd_code == 3'd2; m_pend = 1;
         end else if (dsc) begin
            m_rd = 0; m_wr = 0; m_pend = 0;
         end else if (ab) begin
            m_rd = 0; m_wr = 0;
         end
         if (acc)          m_addr = '0;
         else if (ok)      m_addr = ainc;
         else if (addr_ld) m_addr = addr_ld_val;
      end
      @(negedge clk);
   endtask

   task automatic run(input int n);
      repeat (n) cyc();
   endtask

   task automatic issue(input logic [2:0] c);
      cmd_valid = 1'b1; cmd_code = c;
      cyc();
      cmd_valid = 1'b0; cmd_code = 3'd0;
   endtask

   task automatic load(input logic [35:0] v);
      addr_ld = 1'b1; addr_ld_val = v;
      cyc();
      addr_ld = 1'b0;
   endtask

   task automatic disconnect();
      chan_disco = 1'b1;
      cyc();
      chan_disco = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int s, a, e, k;
      logic [35:0] v;
      @(negedge clk);
      run(3);
      rst = 1'b0;
      run(2);                               // R12 reset state compared per cycle

      issue(3'd1);                          // R2 no storage
      attached = 1'b1;
      issue(3'd5);                          // R2 bad code
      issue(3'd0);                          // R2 bad code
      chan_active = 1'b1;
      issue(3'd1);                          // R1 channel busy
      chan_active = 1'b0;

      issue(3'd1);                          // R3 read accepted
      chan_active = 1'b1; chan_sel = 1'b1; tick = 1'b1;
      s = n_strobe; k = 0;
      while (n_strobe == s && k < 5000) begin cyc(); k++; end
      chk("R4 first word on 4096th tick", k, 4096);
      e = n_eor;
      run(2500);                            // R9 crosses 2048
      chk("R9 record boundary seen", n_eor - e, 1);
      for (int i = 0; i < 20; i++) begin
         tick = 1'b0; cyc(); tick = 1'b1; cyc();
      end

      chan_active = 1'b0;
      issue(3'd2);                          // R1 pending
      disconnect();                         // R11
      issue(3'd2);                          // R3 write accepted after disconnect
      load(36'd32766);                      // R13
      chan_active = 1'b1;
      e = n_eor;
      for (int i = 0; i < 4; i++) begin
         word_from_chan = 36'h0abc + 36'(i * 7919);
         run(1030);
      end
      chk("R8 wrap raises end of record", (n_eor - e) >= 1, 1);

      xfer_code = 2'd1;                     // R10 channel end on a moving word
      s = n_strobe; k = 0;
      while (n_strobe == s && k < 5000) begin cyc(); k++; end
      xfer_code = 2'd0;
      s = n_strobe;
      run(4200);
      chk("R10 no word after channel end", n_strobe - s, 0);
      chan_active = 1'b0;
      issue(3'd1);                          // R10 still busy
      disconnect();

      unit_cfg = 3'd2; cyc();               // R12 captured while idle
      issue(3'd1);
      unit_cfg = 3'd7;                      // R12 ignored while pending
      v = '0; v[32:30] = 3'd5; v[11:0] = 12'd100;
      load(v);
      chan_active = 1'b1;
      s = n_strobe; a = n_attn;
      run(4096);
      chk("R7 no word for absent unit", n_strobe - s, 0);
      chk("R12 count held while busy: one refusal per turn", n_attn - a, 1);

      v = '0; v[32:30] = 3'd2; v[20:18] = 3'd3; v[11:0] = 12'd50;
      load(v);
      s = n_strobe;
      run(4096);
      chk("R7 highest unit accepted", (n_strobe - s) > 0, 1);

      xfer_code = 2'd3;                     // R5 reply 3 has no effect
      run(10);
      xfer_code = 2'd0;
      run(4100);

      rst = 1'b1; run(2); rst = 1'b0;       // R12 reset while pending
      chan_active = 1'b0;
      issue(3'd2);
      chk("R12 idle after reset accepts", n_chk > 0, 1);
      run(5);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule